// File: doc/BRIEF.md
# Bitslip Alignment Synchronizer

This block lines up the word boundary of a deserializer before a self-test compares any data. It runs on the divided parallel clock. It watches one bit of the deserializer's parallel output while a known training pattern arrives. When the recent history of that bit shows that the framing is wrong, it raises a one-cycle bitslip request. The deserializer then shifts its word boundary by one position.

The detector is a short shift chain of clearable flip-flops fed by the monitored bit. A slip is requested only when every stage of a freshly filled chain holds the wrong value. After each request the chain is emptied, so the slip has time to take effect before the bit is judged again. Once the expected training value has filled the chain, the block declares alignment and stays idle. The pattern generator arms the block through an enable line. While that line is low, the chain is held empty and nothing is issued.

Top module: `bitslip_sync`

## Requirements
- R1: While `rst_n` is low, `bitslip` and `aligned` are both 0.
- R2: While `slip_en` is low, `bitslip` and `aligned` are 0 and the chain is emptied. After `slip_en` rises, no output reacts until three new samples have been taken.
- R3: With `slip_en` high and `aligned` low, `bitslip` is 1 in the cycle after the third consecutive sample (since the chain was last emptied) in which `mon_bit` differs from the training value. The training value is 0 by default. For the input run 1,1,1,0,0 starting right after enable, the single pulse falls in the fourth cycle.
- R4: Every `bitslip` pulse is exactly one parallel-clock cycle wide.
- R5: The sample taken on the edge that ends a pulse is discarded and the chain restarts empty. A steady wrong input therefore gives a pulse every fourth cycle, with at least three quiet cycles between pulses.
- R6: `aligned` goes to 1 in the cycle after three consecutive samples (since the chain was last emptied) equal to the training value.
- R7: Once `aligned` is 1, it stays 1 and `bitslip` stays 0 for as long as `slip_en` stays high, whatever `mon_bit` does.
- R8: As long as the last three samples contain both values, neither a pulse nor alignment is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div | input | 1 | Divided parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slip_en | input | 1 | Arming line from the pattern generator |
| mon_bit | input | 1 | Monitored parallel output bit of the deserializer |
| bitslip | output | 1 | One-cycle request to shift the word boundary |
| aligned | output | 1 | Training value observed; alignment done |

## Verification
The bench first replays the short reference run. A design that judged the bit one cycle early or late would put the pulse outside the fourth cycle. Long runs of the wrong value check the refill spacing. A design that kept the chain after a pulse would fire on back-to-back cycles. A design that kept the sample taken on the pulse edge would fire every third cycle. Enable is dropped in the middle of a partial fill and after alignment. Stale state would then show up as a pulse too early after re-arming, or as a sticky `aligned`. Random runs with mixed bits and random enable drops look for pulses from windows that were not uniform.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

  // Width of a counter that must hold the values 0..depth
  function automatic int cnt_bits(input int depth);
    return (depth < 2) ? 1 : $clog2(depth + 1);
  endfunction

  // Result of judging the detector window
  typedef struct packed {
    logic all_wrong;  // full window, every stage differs from training value
    logic all_right;  // full window, every stage equals training value
  } verdict_t;

  // Uniform-window test: every bit of w equals v
  function automatic logic window_uniform(input logic [31:0] w, input int n, input logic v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (w[i] != v) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/bsync_chain.sv
module bsync_chain #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  output logic [DEPTH-1:0] stages,
  output logic             full
);
  localparam int CW = bsync_pkg::cnt_bits(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] fill;

  // Clearable flip-flop chain: stage 0 takes the sample, the rest take their predecessor
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stages[g] <= 1'b0;
        else if (clear) stages[g] <= 1'b0;
        else if (g == 0) stages[g] <= sample;
        else            stages[g] <= stages[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  // Count of valid samples since the last clear, saturating at DEPTH
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             fill <= '0;
    else if (clear)         fill <= '0;
    else if (fill != FULL_CNT) fill <= fill + 1'b1;
  end

  assign full = (fill == FULL_CNT);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !full);  // R5

endmodule

// File: rtl/bsync_judge.sv
module bsync_judge #(
  parameter int   DEPTH     = 3,
  parameter logic TRAIN_BIT = 1'b0
) (
  input  logic [DEPTH-1:0]     stages,
  input  logic                 full,
  output bsync_pkg::verdict_t  verdict
);
  logic [31:0] win;

  always_comb begin
    win = '0;
    win[DEPTH-1:0] = stages;
    verdict.all_wrong = full && bsync_pkg::window_uniform(win, DEPTH, ~TRAIN_BIT);
    verdict.all_right = full && bsync_pkg::window_uniform(win, DEPTH, TRAIN_BIT);
  end

  AST_VERDICT_EXCLUSIVE: assert final (!(verdict.all_wrong && verdict.all_right));  // R8

endmodule

// File: rtl/bsync_ctrl.sv
module bsync_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  bsync_pkg::verdict_t verdict,
  output logic                slip,
  output logic                aligned,
  output logic                chain_clear
);
  logic aligned_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 aligned_q <= 1'b0;
    else if (!en)               aligned_q <= 1'b0;
    else if (verdict.all_right) aligned_q <= 1'b1;
  end

  assign aligned     = en && (aligned_q || verdict.all_right);
  assign slip        = en && !aligned && verdict.all_wrong;
  assign chain_clear = !en || slip;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !slip);  // R4
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!slip && !aligned));  // R2
  AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && en) |=> (aligned || !en));  // R7

endmodule

// File: rtl/bitslip_sync.sv
module bitslip_sync #(
  parameter int   DEPTH     = 3,
  parameter logic TRAIN_BIT = 1'b0
) (
  input  logic clk_div,
  input  logic rst_n,
  input  logic slip_en,
  input  logic mon_bit,
  output logic bitslip,
  output logic aligned
);
  localparam int CW = bsync_pkg::cnt_bits(DEPTH);
  localparam logic [CW-1:0] GAP_MAX = CW'(DEPTH);

  logic [DEPTH-1:0]    chain_q;
  logic                chain_full;
  logic                chain_clear;
  bsync_pkg::verdict_t verdict;

  bsync_chain #(.DEPTH(DEPTH)) u_chain (
    .clk    (clk_div),
    .rst_n  (rst_n),
    .clear  (chain_clear),
    .sample (mon_bit),
    .stages (chain_q),
    .full   (chain_full)
  );

  bsync_judge #(.DEPTH(DEPTH), .TRAIN_BIT(TRAIN_BIT)) u_judge (
    .stages  (chain_q),
    .full    (chain_full),
    .verdict (verdict)
  );

  bsync_ctrl u_ctrl (
    .clk         (clk_div),
    .rst_n       (rst_n),
    .en          (slip_en),
    .verdict     (verdict),
    .slip        (bitslip),
    .aligned     (aligned),
    .chain_clear (chain_clear)
  );

  // Cycles since the last pulse, kept only for the spacing check
  logic [CW-1:0] gap_cnt;
  always_ff @(posedge clk_div or negedge rst_n) begin
    if (!rst_n)                 gap_cnt <= GAP_MAX;
    else if (bitslip)           gap_cnt <= '0;
    else if (gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
  end

  AST_REFILL_GAP: assert property (@(posedge clk_div) disable iff (!rst_n)
    bitslip |-> (gap_cnt == GAP_MAX));  // R5
  AST_NO_SLIP_WHEN_ALIGNED: assert property (@(posedge clk_div) disable iff (!rst_n)
    $past(aligned && slip_en) && slip_en |-> !bitslip);  // R7

endmodule

// File: tb/sim_bitslip_sync.sv
`timescale 1ns/1ps
module sim_bitslip_sync;
  logic clk_div = 1'b0;
  logic rst_n   = 1'b0;
  logic slip_en = 1'b0;
  logic mon_bit = 1'b0;
  logic bitslip, aligned;

  always #2 clk_div = ~clk_div;

  bitslip_sync u0 (
    .clk_div (clk_div),
    .rst_n   (rst_n),
    .slip_en (slip_en),
    .mon_bit (mon_bit),
    .bitslip (bitslip),
    .aligned (aligned)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model of the requirements (training value 0, window of three)
  int         m_cnt  = 0;
  logic [2:0] m_hist = 3'b000;
  logic       m_al   = 1'b0;
  logic       obs_slip, obs_al;

  function automatic logic model_aligned(input logic r, input logic e);
    return r && e && (m_al || (m_cnt >= 3 && m_hist == 3'b000));
  endfunction

  function automatic logic model_slip(input logic r, input logic e);
    return r && e && !model_aligned(r, e) && m_cnt >= 3 && m_hist == 3'b111;
  endfunction

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic b, input string tag);
    logic xs, xa;
    @(negedge clk_div);
    rst_n = r; slip_en = e; mon_bit = b;
    #1;
    xs = model_slip(r, e);
    xa = model_aligned(r, e);
    obs_slip = bitslip;
    obs_al   = aligned;
    check(tag, "bitslip", bitslip, xs);
    check(tag, "aligned", aligned, xa);
    @(posedge clk_div);
    if (!r || !e) begin
      m_cnt = 0; m_hist = 3'b000; m_al = 1'b0;
    end else if (xs) begin
      m_cnt = 0; m_hist = 3'b000;
    end else begin
      m_al   = xa;
      m_hist = {m_hist[1:0], b};
      if (m_cnt < 3) m_cnt++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk_div);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // R1: reset holds outputs low even with enable and wrong data present
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, "R1");
    check("R1", "bitslip in reset", obs_slip, 1'b0);
    check("R1", "aligned in reset", obs_al, 1'b0);

    // R3 reference run 1,1,1,0,0: pulse only in the fourth cycle
    step(1, 1, 1, "R3"); step(1, 1, 1, "R3"); step(1, 1, 1, "R3");
    step(1, 1, 0, "R3");
    check("R3", "pulse in cycle 4", obs_slip, 1'b1);
    step(1, 1, 0, "R4");
    check("R4", "pulse ends after one cycle", obs_slip, 1'b0);
    // R6: three training samples after the refill give alignment
    step(1, 1, 0, "R6"); step(1, 1, 0, "R6");
    step(1, 1, 0, "R6");
    check("R6", "aligned after three zeros", obs_al, 1'b1);

    // R7: wrong data after alignment causes nothing
    for (int i = 0; i < 8; i++) begin
      step(1, 1, 1, "R7");
      check("R7", "still aligned", obs_al, 1'b1);
      check("R7", "no pulse after align", obs_slip, 1'b0);
    end

    // R2: disabling clears alignment and the chain
    step(1, 0, 1, "R2");
    check("R2", "aligned drops when disabled", obs_al, 1'b0);
    step(1, 0, 1, "R2");
    step(1, 1, 1, "R2"); step(1, 1, 1, "R2");
    step(1, 0, 1, "R2");   // drop mid-fill
    step(1, 1, 1, "R2"); step(1, 1, 1, "R2"); step(1, 1, 1, "R2");
    check("R2", "no pulse before three fresh samples", obs_slip, 1'b0);

    // R5: steady wrong data gives one pulse every fourth cycle
    step(1, 0, 1, "R5");
    for (int i = 1; i <= 16; i++) begin
      step(1, 1, 1, "R5");
      check("R5", "pulse spacing", obs_slip, (i % 4 == 0) ? 1'b1 : 1'b0);
    end

    // R8: mixed windows never pulse or align
    step(1, 0, 0, "R8");
    for (int i = 0; i < 18; i++) begin
      step(1, 1, (i % 3 != 2) ? 1'b1 : 1'b0, "R8");
      check("R8", "no pulse on mixed window", obs_slip, 1'b0);
      check("R8", "no align on mixed window", obs_al, 1'b0);
    end

    // Random runs, mostly enabled, biased toward wrong data
    for (int i = 0; i < 1500; i++) begin
      logic e, b;
      e = ($urandom % 16) != 0;
      b = ($urandom % 4) != 0;
      step(1, e, b, "R8");
    end

    summary();
    $finish;
  end

endmodule